// File: doc/BRIEF.md
# Device Error Signaling Classifier

The block takes at most one reported error event per clock. Each event has a status vector, a correctable flag, an advisory flag and a 16-bit source ID. The block first checks that the event names exactly one supported error. It then sorts the event into correctable, non-fatal or fatal. From that result it updates three registers: the device-level error flags, the correctable status register and the uncorrectable status register. The mask registers and the per-bit severity register decide what happens next.

From the legacy system-error enable and the per-class report enables, the block decides whether to send an error message upward. A message is a one-cycle pulse with a 2-bit severity code and the source ID. Uncorrectable errors that are not masked also raise a one-cycle request to a header logger. If that logger later reports that its queue overflowed, the block injects its own correctable header-log-overflow event. It does this in the first cycle that has no external event.

Software access is modelled with plain ports: a configuration write port for the masks and the severity register, and write-one-to-clear strobes for the status registers. All outputs are registered. The outputs for an event appear one clock after the event is presented.

Top module: `err_signal_classifier`

## Requirements
- R1: After masking to the supported bits, an event must have exactly one bit set. The supported bits are bits 0..7 for a correctable event and bits 0..15 for an uncorrectable one. An event with zero bits or several bits set after this masking pulses `ev_reject` and changes no status. It also sends no message and makes no log request. Set bits outside the supported range are dropped before the count is taken.
- R2: A correctable report sets `dev_sts[0]`. If the error is an uncorrectable unsupported request (bit 8) taken down the correctable path, the report also sets `dev_sts[3]`.
- R3: Bit n of the severity register marks uncorrectable bit n as fatal. After reset the register holds 16'h003F, so bits 0..5 are fatal and bits 6..15 are non-fatal. `cfg_sel`=2 overwrites the register.
- R4: An uncorrectable error whose bit is set in the uncorrectable mask (`cfg_sel`=1) still sets its status bit and its `dev_sts` class bit. It produces no log request and no message.
- R5: A correctable error whose bit is set in the correctable mask (`cfg_sel`=0) sets its correctable status bit and sends no message.
- R6: A correctable message (severity code 0) is sent only when `cor_rep_en` is set. For an unsupported request, `ur_rep_en` must also be set.
- R7: An unmasked uncorrectable error sets `dev_sts[2]` if it is fatal, otherwise `dev_sts[1]`, and sets `dev_sts[3]` if it is bit 8. A fatal message (code 2) needs `serr_en` or `fat_rep_en`. A non-fatal message (code 1) needs `serr_en` or `nf_rep_en`. An unsupported request sends nothing when both `ur_rep_en` and `serr_en` are clear.
- R8: A non-fatal uncorrectable event with `ev_advisory` set is downgraded to a correctable report of advisory bit 5. If bit 5 is not masked in the correctable mask, the report also sets the original uncorrectable status bit. It requests logging only if the original bit is not masked in the uncorrectable mask. If bit 5 is masked, only correctable bit 5 and `dev_sts[0]` are set.
- R9: A `log_ovf` pulse makes the block inject a correctable event on bit 7 with source ID 0. The injection happens in the first cycle after the pulse in which `ev_valid` is low.
- R10: A message is a one-cycle `msg_valid` pulse carrying `msg_sev` (0 correctable, 1 non-fatal, 2 fatal) and `msg_src`. The pulse appears on the clock after the event. The log request `log_req` is a one-cycle pulse with the one-hot `log_vec`.
- R11: The `clr_*` inputs clear status bits written as one. A hardware set of the same bit in the same cycle wins.
- R12: Every unmasked uncorrectable error takes the log request path, fatal and non-fatal alike, and `log_vec` names its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Error event present this cycle |
| ev_status | input | 32 | Event status vector |
| ev_correctable | input | 1 | Event is correctable |
| ev_advisory | input | 1 | Event may be downgraded to an advisory report |
| ev_src | input | 16 | Event source ID |
| serr_en | input | 1 | Legacy system-error enable |
| cor_rep_en | input | 1 | Correctable report enable |
| nf_rep_en | input | 1 | Non-fatal report enable |
| fat_rep_en | input | 1 | Fatal report enable |
| ur_rep_en | input | 1 | Unsupported-request report enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 correctable mask, 1 uncorrectable mask, 2 severity |
| cfg_wdata | input | 16 | Configuration write data |
| clr_dev | input | 4 | Write-one-to-clear for the device flags |
| clr_cor | input | 8 | Write-one-to-clear for the correctable status |
| clr_unc | input | 16 | Write-one-to-clear for the uncorrectable status |
| log_ovf | input | 1 | Logger reports a queue overflow |
| ev_reject | output | 1 | Previous event was malformed |
| msg_valid | output | 1 | Error message pulse |
| msg_sev | output | 2 | Message severity code |
| msg_src | output | 16 | Message source ID |
| log_req | output | 1 | Header log request pulse |
| log_vec | output | 16 | One-hot uncorrectable bit to log |
| dev_sts | output | 4 | Device flags: 0 correctable, 1 non-fatal, 2 fatal, 3 unsupported request |
| cor_sts | output | 8 | Correctable status register |
| unc_sts | output | 16 | Uncorrectable status register |

## Verification
The bench targets these corner cases:
- A correctable event with one supported bit and one bit above the supported range. A design that counted bits before masking would wrongly reject it.
- An advisory downgrade while bit 5 is masked. A design that ignored this would set the uncorrectable bit or raise a log request.
- An unsupported request whose report enable is off but whose system-error enable is on. A design that got this wrong would drop or wrongly send the message.
- A clear and a set of the same status bit in one cycle. A set-loses design would leave the bit clear.
- A logger overflow that lands while external events keep arriving. A wrong design would lose the injected header-log-overflow report or let it take the place of a real event.

// File: rtl/esc_pkg.sv
package esc_pkg;
  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2
  } sev_e;

  localparam int DEV_COR = 0;
  localparam int DEV_NF  = 1;
  localparam int DEV_FAT = 2;
  localparam int DEV_UR  = 3;
  localparam int DEV_W   = 4;
endpackage

// File: rtl/esc_decode.sv
module esc_decode #(
  parameter int EV_W  = 32,
  parameter int COR_W = 8,
  parameter int UNC_W = 16,
  parameter logic [COR_W-1:0] COR_SUPP = '1,
  parameter logic [UNC_W-1:0] UNC_SUPP = '1
) (
  input  logic [EV_W-1:0]  status,
  input  logic             correctable,
  output logic             one_hot,
  output logic [COR_W-1:0] cor_bit,
  output logic [UNC_W-1:0] unc_bit
);
  localparam logic [EV_W-1:0] COR_EXT = EV_W'(COR_SUPP);
  localparam logic [EV_W-1:0] UNC_EXT = EV_W'(UNC_SUPP);

  logic [EV_W-1:0] masked;

  always_comb begin
    masked  = status & (correctable ? COR_EXT : UNC_EXT);
    one_hot = (masked != '0) && ((masked & (masked - EV_W'(1))) == '0);
    cor_bit = masked[COR_W-1:0];
    unc_bit = masked[UNC_W-1:0];
  end
endmodule

// File: rtl/esc_policy.sv
module esc_policy
  import esc_pkg::*;
#(
  parameter int COR_W   = 8,
  parameter int UNC_W   = 16,
  parameter int UR_BIT  = 8,
  parameter int ADV_BIT = 5
) (
  input  logic             go,
  input  logic             correctable,
  input  logic             advisory,
  input  logic [COR_W-1:0] cor_bit,
  input  logic [UNC_W-1:0] unc_bit,
  input  logic [COR_W-1:0] cor_mask,
  input  logic [UNC_W-1:0] unc_mask,
  input  logic [UNC_W-1:0] unc_sev,
  input  logic             serr_en,
  input  logic             cor_rep_en,
  input  logic             nf_rep_en,
  input  logic             fat_rep_en,
  input  logic             ur_rep_en,
  output logic [DEV_W-1:0] set_dev,
  output logic [COR_W-1:0] set_cor,
  output logic [UNC_W-1:0] set_unc,
  output logic             log_now,
  output logic             msg_now,
  output sev_e             msg_sev
);
  localparam logic [COR_W-1:0] ADV_VEC = COR_W'(1) << ADV_BIT;

  logic             is_ur, fatal, downgrade, cor_path, cor_masked, unc_masked;
  logic [COR_W-1:0] cbit;

  always_comb begin
    is_ur      = !correctable && unc_bit[UR_BIT];
    fatal      = !correctable && ((unc_bit & unc_sev) != '0);
    downgrade  = !correctable && !fatal && advisory;
    cor_path   = correctable || downgrade;
    cbit       = correctable ? cor_bit : ADV_VEC;
    cor_masked = (cbit & cor_mask) != '0;
    unc_masked = (unc_bit & unc_mask) != '0;

    set_dev = '0;
    set_cor = '0;
    set_unc = '0;
    log_now = 1'b0;
    msg_now = 1'b0;
    msg_sev = SEV_COR;

    if (go) begin
      set_dev[DEV_UR] = is_ur;
      if (cor_path) begin
        set_dev[DEV_COR] = 1'b1;
        set_cor          = cbit;
        if (!cor_masked) begin
          if (downgrade) begin
            set_unc = unc_bit;
            log_now = !unc_masked;
          end
          msg_now = cor_rep_en && (!is_ur || ur_rep_en);
        end
      end else begin
        set_dev[fatal ? DEV_FAT : DEV_NF] = 1'b1;
        set_unc = unc_bit;
        msg_sev = fatal ? SEV_FATAL : SEV_NONFATAL;
        if (!unc_masked) begin
          log_now = 1'b1;
          msg_now = !(is_ur && !ur_rep_en && !serr_en) &&
                    (serr_en || (fatal ? fat_rep_en : nf_rep_en));
        end
      end
    end
  end
endmodule

// File: rtl/esc_w1c.sv
module esc_w1c #(
  parameter int          W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST;
    else     q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/err_signal_classifier.sv
module err_signal_classifier
  import esc_pkg::*;
#(
  parameter int EV_W    = 32,
  parameter int SRC_W   = 16,
  parameter int COR_W   = 8,
  parameter int UNC_W   = 16,
  parameter int UR_BIT  = 8,
  parameter int ADV_BIT = 5,
  parameter int HLO_BIT = 7,
  parameter logic [COR_W-1:0] COR_SUPP    = '1,
  parameter logic [UNC_W-1:0] UNC_SUPP    = '1,
  parameter logic [UNC_W-1:0] SEV_DEFAULT = UNC_W'(16'h003F)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic [EV_W-1:0]  ev_status,
  input  logic             ev_correctable,
  input  logic             ev_advisory,
  input  logic [SRC_W-1:0] ev_src,
  input  logic             serr_en,
  input  logic             cor_rep_en,
  input  logic             nf_rep_en,
  input  logic             fat_rep_en,
  input  logic             ur_rep_en,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [UNC_W-1:0] cfg_wdata,
  input  logic [3:0]       clr_dev,
  input  logic [COR_W-1:0] clr_cor,
  input  logic [UNC_W-1:0] clr_unc,
  input  logic             log_ovf,
  output logic             ev_reject,
  output logic             msg_valid,
  output logic [1:0]       msg_sev,
  output logic [SRC_W-1:0] msg_src,
  output logic             log_req,
  output logic [UNC_W-1:0] log_vec,
  output logic [3:0]       dev_sts,
  output logic [COR_W-1:0] cor_sts,
  output logic [UNC_W-1:0] unc_sts
);
  localparam logic [EV_W-1:0] HLO_VEC = EV_W'(1) << HLO_BIT;

  // pending injected overflow event
  logic ovf_pend;
  logic use_int, go_v;
  logic [EV_W-1:0]  sel_status;
  logic             sel_corr, sel_adv;
  logic [SRC_W-1:0] sel_src;

  always_comb begin
    use_int    = !ev_valid && ovf_pend;
    go_v       = ev_valid || use_int;
    sel_status = ev_valid ? ev_status : HLO_VEC;
    sel_corr   = ev_valid ? ev_correctable : 1'b1;
    sel_adv    = ev_valid && ev_advisory;
    sel_src    = ev_valid ? ev_src : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) ovf_pend <= 1'b0;
    else     ovf_pend <= log_ovf || (ovf_pend && ev_valid);
  end

  logic             one_hot;
  logic [COR_W-1:0] cor_bit;
  logic [UNC_W-1:0] unc_bit;

  esc_decode #(
    .EV_W(EV_W), .COR_W(COR_W), .UNC_W(UNC_W),
    .COR_SUPP(COR_SUPP), .UNC_SUPP(UNC_SUPP)
  ) u_decode (
    .status(sel_status), .correctable(sel_corr),
    .one_hot(one_hot), .cor_bit(cor_bit), .unc_bit(unc_bit)
  );

  // configuration registers
  logic [COR_W-1:0] cor_mask;
  logic [UNC_W-1:0] unc_mask, unc_sev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cor_mask <= '0;
      unc_mask <= '0;
      unc_sev  <= SEV_DEFAULT;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0:    cor_mask <= cfg_wdata[COR_W-1:0];
        2'd1:    unc_mask <= cfg_wdata;
        2'd2:    unc_sev  <= cfg_wdata;
        default: ;
      endcase
    end
  end

  logic [DEV_W-1:0] set_dev;
  logic [COR_W-1:0] set_cor;
  logic [UNC_W-1:0] set_unc;
  logic             log_now, msg_now;
  sev_e             sev_now;

  esc_policy #(
    .COR_W(COR_W), .UNC_W(UNC_W), .UR_BIT(UR_BIT), .ADV_BIT(ADV_BIT)
  ) u_policy (
    .go(go_v && one_hot), .correctable(sel_corr), .advisory(sel_adv),
    .cor_bit(cor_bit), .unc_bit(unc_bit),
    .cor_mask(cor_mask), .unc_mask(unc_mask), .unc_sev(unc_sev),
    .serr_en(serr_en), .cor_rep_en(cor_rep_en), .nf_rep_en(nf_rep_en),
    .fat_rep_en(fat_rep_en), .ur_rep_en(ur_rep_en),
    .set_dev(set_dev), .set_cor(set_cor), .set_unc(set_unc),
    .log_now(log_now), .msg_now(msg_now), .msg_sev(sev_now)
  );

  esc_w1c #(.W(DEV_W)) u_dev (.clk(clk), .rst(rst), .set(set_dev), .clr(clr_dev), .q(dev_sts));
  esc_w1c #(.W(COR_W)) u_cor (.clk(clk), .rst(rst), .set(set_cor), .clr(clr_cor), .q(cor_sts));
  esc_w1c #(.W(UNC_W)) u_unc (.clk(clk), .rst(rst), .set(set_unc), .clr(clr_unc), .q(unc_sts));

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_reject <= 1'b0;
      msg_valid <= 1'b0;
      msg_sev   <= SEV_COR;
      msg_src   <= '0;
      log_req   <= 1'b0;
      log_vec   <= '0;
    end else begin
      ev_reject <= go_v && !one_hot;
      msg_valid <= msg_now;
      msg_sev   <= sev_now;
      msg_src   <= sel_src;
      log_req   <= log_now;
      log_vec   <= log_now ? unc_bit : '0;
    end
  end
endmodule

// File: rtl/esc_checker.sv
module esc_checker #(
  parameter int COR_W = 8,
  parameter int UNC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_reject,
  input logic             msg_valid,
  input logic [1:0]       msg_sev,
  input logic             log_req,
  input logic [UNC_W-1:0] log_vec,
  input logic [3:0]       dev_sts,
  input logic [COR_W-1:0] cor_sts,
  input logic [UNC_W-1:0] unc_sts,
  input logic [3:0]       clr_dev,
  input logic [COR_W-1:0] clr_cor,
  input logic [UNC_W-1:0] clr_unc
);
  assert_sev_code_R10: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (msg_sev != 2'd3));

  assert_reject_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    ev_reject |-> (!msg_valid && !log_req));

  assert_reject_nostate_R1: assert property (@(posedge clk) disable iff (rst)
    (ev_reject && $past(clr_cor) == '0 && $past(clr_unc) == '0 && $past(clr_dev) == '0)
      |-> ($stable(cor_sts) && $stable(unc_sts) && $stable(dev_sts)));

  assert_log_onehot_R12: assert property (@(posedge clk) disable iff (rst)
    log_req |-> ($countones(log_vec) == 1 && (unc_sts & log_vec) != '0));

  assert_fatal_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_sev == 2'd2) |-> dev_sts[2]);

  assert_cor_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_sev == 2'd0) |-> dev_sts[0]);

  assert_cor_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (($past(cor_sts) & ~$past(clr_cor)) & ~cor_sts) == '0);

  assert_unc_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (($past(unc_sts) & ~$past(clr_unc)) & ~unc_sts) == '0);
endmodule

bind err_signal_classifier esc_checker #(.COR_W(COR_W), .UNC_W(UNC_W)) u_esc_checker (
  .clk(clk), .rst(rst), .ev_reject(ev_reject), .msg_valid(msg_valid),
  .msg_sev(msg_sev), .log_req(log_req), .log_vec(log_vec),
  .dev_sts(dev_sts), .cor_sts(cor_sts), .unc_sts(unc_sts),
  .clr_dev(clr_dev), .clr_cor(clr_cor), .clr_unc(clr_unc)
);

// File: tb/test_err_signal_classifier.sv
module test_err_signal_classifier;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        ev_valid = 0, ev_correctable = 0, ev_advisory = 0;
  logic [31:0] ev_status = 0;
  logic [15:0] ev_src = 0;
  logic        serr_en = 0, cor_rep_en = 0, nf_rep_en = 0, fat_rep_en = 0, ur_rep_en = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [15:0] cfg_wdata = 0;
  logic [3:0]  clr_dev = 0;
  logic [7:0]  clr_cor = 0;
  logic [15:0] clr_unc = 0;
  logic        log_ovf = 0;
  logic        ev_reject, msg_valid, log_req;
  logic [1:0]  msg_sev;
  logic [15:0] msg_src, log_vec, unc_sts;
  logic [3:0]  dev_sts;
  logic [7:0]  cor_sts;

  err_signal_classifier i_err_signal_classifier (.*);

  int checks = 0, failures = 0;

  // reference state
  logic [3:0]  m_dev;  logic [7:0] m_cor, m_cmask; logic [15:0] m_unc, m_umask, m_sev;
  logic        m_pend;
  logic        e_rej, e_msgv, e_log; logic [1:0] e_sev; logic [15:0] e_src, e_logv;
  logic [3:0]  n_dev;  logic [7:0] n_cor; logic [15:0] n_unc;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_dev = 0; m_cor = 0; m_unc = 0; m_cmask = 0; m_umask = 0;
    m_sev = 16'h003F; m_pend = 0;
  endtask

  task automatic model_eval();
    logic [31:0] sv, m; logic corr, adv, go, ur, fat;
    logic [3:0] sd; logic [7:0] sc, cb; logic [15:0] su;
    go = ev_valid || m_pend;
    if (ev_valid) begin sv = ev_status; corr = ev_correctable; adv = ev_advisory; e_src = ev_src; end
    else begin sv = 32'h80; corr = 1; adv = 0; e_src = 0; end
    m = sv & (corr ? 32'h000000FF : 32'h0000FFFF);
    e_rej = go && ($countones(m) != 1);
    e_msgv = 0; e_log = 0; e_logv = 0; e_sev = 0; sd = 0; sc = 0; su = 0;
    if (go && $countones(m) == 1) begin
      ur  = !corr && m[8];
      fat = !corr && ((m[15:0] & m_sev) != 0);
      sd[3] = ur;
      if (corr || (!fat && adv)) begin
        cb = corr ? m[7:0] : 8'h20;
        sd[0] = 1; sc = cb;
        if ((cb & m_cmask) == 0) begin
          if (!corr) begin su = m[15:0]; e_log = (m[15:0] & m_umask) == 0; e_logv = e_log ? m[15:0] : 0; end
          e_msgv = cor_rep_en && (!ur || ur_rep_en);
        end
      end else begin
        sd[fat ? 2 : 1] = 1; su = m[15:0]; e_sev = fat ? 2 : 1;
        if ((m[15:0] & m_umask) == 0) begin
          e_log = 1; e_logv = m[15:0];
          e_msgv = !(ur && !ur_rep_en && !serr_en) && (serr_en || (fat ? fat_rep_en : nf_rep_en));
        end
      end
    end
    n_dev = (m_dev & ~clr_dev) | sd;
    n_cor = (m_cor & ~clr_cor) | sc;
    n_unc = (m_unc & ~clr_unc) | su;
  endtask

  task automatic step();
    model_eval();
    @(posedge clk); #1;
    check("R1 reject", ev_reject, e_rej);
    check("R6 R7 R10 msg_valid", msg_valid, e_msgv);
    if (e_msgv && msg_valid) check("R10 sev/src", {msg_sev, msg_src}, {e_sev, e_src});
    check("R4 R12 log", {log_req, log_vec}, {e_log, e_logv});
    check("R2 R7 dev_sts", dev_sts, n_dev);
    check("R11 cor_sts", cor_sts, n_cor);
    check("R11 unc_sts", unc_sts, n_unc);
    m_dev = n_dev; m_cor = n_cor; m_unc = n_unc;
    if (cfg_we) case (cfg_sel)
      2'd0: m_cmask = cfg_wdata[7:0];
      2'd1: m_umask = cfg_wdata;
      2'd2: m_sev = cfg_wdata;
      default: ;
    endcase
    m_pend = log_ovf || (m_pend && ev_valid);
    ev_valid = 0; ev_advisory = 0; cfg_we = 0; clr_dev = 0; clr_cor = 0; clr_unc = 0; log_ovf = 0;
  endtask

  task automatic ev(logic [31:0] st, logic c, logic a, logic [15:0] s);
    ev_valid = 1; ev_status = st; ev_correctable = c; ev_advisory = a; ev_src = s;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_ABCD));
    model_reset();
    repeat (4) @(posedge clk);
    #1 rst = 0;
    check("R10 reset msg", {ev_reject, msg_valid, log_req}, 0);
    check("R11 reset status", {dev_sts, cor_sts, unc_sts}, 0);

    // R3 default severity: bit 2 fatal via fatal report enable
    fat_rep_en = 1; ev(32'h4, 0, 0, 16'hA001); step();
    check("R3 default fatal", {msg_valid, msg_sev, msg_src}, {1'b1, 2'd2, 16'hA001});
    // R3 bit 6 non-fatal
    nf_rep_en = 1; ev(32'h40, 0, 0, 16'hA002); step();
    check("R3 default nonfatal", {msg_valid, msg_sev}, {1'b1, 2'd1});
    // R1 two bits rejected
    ev(32'h3, 0, 0, 16'h1); step();
    check("R1 two bits", {ev_reject, msg_valid}, 2'b10);
    // R1 unsupported high bit dropped, bit1 kept
    cor_rep_en = 1; ev(32'h0010_0002, 1, 0, 16'hB0B0); step();
    check("R1 masked high bit", {ev_reject, msg_valid, msg_sev}, {1'b0, 1'b1, 2'd0});
    // R7 unsupported request via SERR with UR enable off
    serr_en = 1; ur_rep_en = 0; nf_rep_en = 0; ev(32'h100, 0, 0, 16'hC); step();
    check("R7 UR via serr", {msg_valid, msg_sev, dev_sts[3]}, {1'b1, 2'd1, 1'b1});
    serr_en = 0;
    // R8 advisory downgrade
    ev(32'h200, 0, 1, 16'hD); step();
    check("R8 advisory", {msg_valid, msg_sev, log_req, cor_sts[5], unc_sts[9]}, {1'b1, 2'd0, 1'b1, 1'b1, 1'b1});
    // R9 overflow follow-up with external event blocking one cycle
    log_ovf = 1; step();
    ev(32'h1, 1, 0, 16'hE); step();
    check("R9 not while busy", {msg_valid, cor_sts[7]}, 2'b10);
    step();
    check("R9 overflow report", {msg_valid, msg_sev, msg_src, cor_sts[7]}, {1'b1, 2'd0, 16'h0, 1'b1});
    // R11 clear and set same bit
    clr_cor = 8'hFF; ev(32'h2, 1, 0, 16'h1); step();
    check("R11 set wins", cor_sts, 8'h02);
    // R8 with advisory masked in correctable mask
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 16'h0020; step();
    clr_unc = 16'hFFFF; step();
    ev(32'h400, 0, 1, 16'h2); step();
    check("R8 masked advisory", {msg_valid, log_req, unc_sts[10], cor_sts[5]}, 4'b0001);
    // R4 masked uncorrectable
    cfg_we = 1; cfg_sel = 1; cfg_wdata = 16'h0001; step();
    ev(32'h1, 0, 0, 16'h3); step();
    check("R4 masked unc", {msg_valid, log_req, unc_sts[0]}, 3'b001);
    // R5 correctable mask
    cfg_we = 1; cfg_sel = 0; cfg_wdata = 16'h0008; step();
    ev(32'h8, 1, 0, 16'h4); step();
    check("R5 masked cor", {msg_valid, cor_sts[3]}, 2'b01);
    // R6 correctable enable off
    cor_rep_en = 0; ev(32'h10, 1, 0, 16'h5); step();
    check("R6 cor disabled", msg_valid, 0);

    // random
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) begin
        serr_en = r[4]; cor_rep_en = r[5]; nf_rep_en = r[6]; fat_rep_en = r[7]; ur_rep_en = r[8];
      end
      if (r[12:9] != 0) begin
        logic c; int idx; logic [31:0] st;
        c = r[13];
        idx = c ? ($urandom % 10) : ($urandom % 18);
        st = 32'h1 << idx;
        if (r[16:14] == 0) st = st | (32'h1 << ($urandom % 16));
        if (r[16:14] == 1) st = 0;
        ev(st, c, r[17], 16'($urandom));
      end
      if (r[21:18] == 0) begin cfg_we = 1; cfg_sel = 2'($urandom); cfg_wdata = 16'($urandom) & 16'($urandom); end
      if (r[24:22] == 0) begin clr_dev = 4'($urandom); clr_cor = 8'($urandom); clr_unc = 16'($urandom); end
      if (r[28:25] == 0) log_ovf = 1;
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule